// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the control logic of a differential clock generator. It decides how the two clock outputs behave from three asynchronous control inputs: an active-low power-down, an active-low output stop and a three-bit mode code. The block sits next to the analog clock path and the output drivers and steers them. It picks the clock source (the phase-aligned clock, the raw PLL clock or the reference), enables high impedance, or parks both outputs at ground or at the stop level.

Power-down has the highest priority, then stop, then the mode code. The mode code is used only while the block is running. A single settle counter holds the `settled_o` flag low after power-up, after leaving stop and after any change of the two-bit multiplier select. Each of these cases has its own cycle limit. A dwell counter times each stay in the stop and run states and raises two timing-violation flags. One flag marks a stop held too long. The other marks a stop re-entered too soon after the previous stop ended.

All limits are parameters counted in control-clock cycles. Every control input, the multiplier select included, passes through a two-flop synchronizer before it is used.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, whatever the other inputs do, `state_o` is 0 (down), `park_gnd_o` is 1, and `park_stop_o`, `hiz_o`, `settled_o`, `stop_long_o` and `stop_early_o` are 0.
- R2: A change on `pd_ni`, `stop_ni` or `mode_i` reaches `state_o` and the output controls on the third rising clock edge after it, and not on the second.
- R3: While synchronized `pd_ni` is low, `state_o` is 0 and `park_gnd_o` is 1, with `park_stop_o`, `hiz_o`, `settled_o` and both violation flags at 0, whatever `stop_ni` and `mode_i` are.
- R4: With `pd_ni` high and `stop_ni` low, `state_o` is 1 (stop) and `park_stop_o` is 1, while `park_gnd_o` and `hiz_o` are 0 even for a high-impedance mode code. At most one of `park_gnd_o`, `park_stop_o` and `hiz_o` is ever high.
- R5: With both `pd_ni` and `stop_ni` high, `state_o` is 2 (run) and `hiz_o` is 0 for the source codes. Mode 3'b000 (`mode_i[2]` first) gives `src_sel_o` = 0 (phase-aligned), 3'b100 gives 1 (PLL bypass) and 3'b110 gives 2 (reference test). `src_sel_o` is never 3.
- R6: In run, modes 3'b010 and 3'b011 set `hiz_o` to 1, with `src_sel_o` at 0.
- R7: In run, the reserved modes 3'b001, 3'b101 and 3'b111 set `hiz_o` to 1, with `src_sel_o` at 0.
- R8: When the block enters run from stop with no other settle interval pending, `settled_o` stays 0 for `STOP_SETTLE_CYC - 1` cycles and goes to 1 `STOP_SETTLE_CYC` cycles after the run state begins.
- R9: When the block leaves power-down, the settle counter loads `PWRUP_SETTLE_CYC`, and `settled_o` goes to 1 `PWRUP_SETTLE_CYC` cycles after the run state begins. `settled_o` is 0 in the down and stop states.
- R10: Outside power-down, a change on `mult_i` clears `settled_o` on the third rising edge after it. `settled_o` returns to 1 `MULT_SETTLE_CYC` cycles later if no other event intervenes.
- R11: `stop_long_o` goes to 1 once the stop state has lasted `STOP_MAX_CYC` cycles, stays high while stop continues and clears when stop ends.
- R12: On entry into stop, `stop_early_o` is set for the whole of that stop when the preceding run lasted fewer than `RUN_MIN_CYC` cycles and had itself been entered from stop. The flag stays 0 when that run lasted at least `RUN_MIN_CYC` cycles, or when it began at power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode code, asynchronous |
| pd_ni | input | 1 | Active-low power-down, asynchronous |
| stop_ni | input | 1 | Active-low output stop, asynchronous |
| mult_i | input | 2 | Multiplier select, asynchronous |
| state_o | output | 2 | 0 down, 1 stop, 2 run |
| src_sel_o | output | 2 | 0 phase-aligned, 1 PLL, 2 reference |
| hiz_o | output | 1 | Outputs to high impedance |
| park_gnd_o | output | 1 | Outputs parked at ground |
| park_stop_o | output | 1 | Outputs parked at stop level |
| settled_o | output | 1 | Clock path settled |
| stop_long_o | output | 1 | Stop held past its maximum dwell |
| stop_early_o | output | 1 | Stop re-entered before the minimum run dwell |

## Verification
The settle assertions take for granted that every settle limit is at least one cycle. The early-stop check takes for granted that `RUN_MIN_CYC` is at least one. Each input is taken to be held longer than the synchronizer depth, so that any change that enters the block is seen as one clean transition. The bench changes inputs only on falling clock edges and holds each value for whole cycles, so the length of a run or stop state in cycles equals the number of cycles the input was held. It also uses short limits, so that every boundary is reached quickly on both sides.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } pwr_state_e;

  typedef enum logic [1:0] {
    SRC_ALIGN = 2'd0,
    SRC_PLL   = 2'd1,
    SRC_REF   = 2'd2
  } src_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= g_stage[g-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/cg_power_fsm.sv
module cg_power_fsm
  import clkgen_pkg::*;
#(
  parameter int unsigned STOP_MAX_CYC = 10000,
  parameter int unsigned RUN_MIN_CYC  = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_n_s_i,
  input  logic       stop_n_s_i,
  input  logic [2:0] mode_s_i,
  output pwr_state_e state_o,
  output pwr_state_e state_next_o,
  output logic [2:0] mode_o,
  output logic       stop_long_o,
  output logic       stop_early_o
);
  localparam int unsigned DW_LIM = max2(STOP_MAX_CYC, RUN_MIN_CYC);
  localparam int unsigned DW_W   = $clog2(DW_LIM + 1);
  localparam logic [DW_W-1:0] DW_TOP     = DW_W'(DW_LIM);
  localparam logic [DW_W-1:0] STOP_LIM   = DW_W'(STOP_MAX_CYC);
  localparam logic [DW_W-1:0] RUN_LIM_M1 = DW_W'(RUN_MIN_CYC - 1);

  pwr_state_e      state_q, state_d;
  logic [2:0]      mode_q;
  logic [DW_W-1:0] dwell_q;
  logic            from_hold_q, early_q;

  // power-down outranks stop
  always_comb begin
    if (!pd_n_s_i)        state_d = ST_DOWN;
    else if (!stop_n_s_i) state_d = ST_HOLD;
    else                  state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_DOWN;
      mode_q      <= '0;
      dwell_q     <= '0;
      from_hold_q <= 1'b0;
      early_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_s_i;
      if (state_d != state_q)  dwell_q <= '0;
      else if (dwell_q != DW_TOP) dwell_q <= dwell_q + DW_W'(1);
      if (state_d == ST_RUN && state_q != ST_RUN)
        from_hold_q <= (state_q == ST_HOLD);
      // dwell_q holds run length minus one on the exit edge
      if (state_d == ST_HOLD && state_q != ST_HOLD)
        early_q <= (state_q == ST_RUN) && from_hold_q && (dwell_q < RUN_LIM_M1);
      else if (state_d != ST_HOLD)
        early_q <= 1'b0;
    end
  end

  assign state_o      = state_q;
  assign state_next_o = state_d;
  assign mode_o       = mode_q;
  assign stop_long_o  = (state_q == ST_HOLD) && (dwell_q >= STOP_LIM);
  assign stop_early_o = early_q;

  assert_down_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_n_s_i |=> state_q == ST_DOWN);

  assert_long_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_long_o && state_d == ST_HOLD) |=> stop_long_o);

  assert_early_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> $stable(stop_early_o));
endmodule

// File: rtl/cg_settle_timer.sv
module cg_settle_timer
  import clkgen_pkg::*;
#(
  parameter int unsigned MULT_W           = 2,
  parameter int unsigned STOP_SETTLE_CYC  = 20,
  parameter int unsigned MULT_SETTLE_CYC  = 100000,
  parameter int unsigned PWRUP_SETTLE_CYC = 300000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pwr_state_e        state_i,
  input  pwr_state_e        state_next_i,
  input  logic [MULT_W-1:0] mult_s_i,
  output logic              settled_o
);
  localparam int unsigned CNT_LIM =
    max2(max2(STOP_SETTLE_CYC, MULT_SETTLE_CYC), PWRUP_SETTLE_CYC);
  localparam int unsigned CNT_W = $clog2(CNT_LIM + 1);
  localparam logic [CNT_W-1:0] STOP_L  = CNT_W'(STOP_SETTLE_CYC);
  localparam logic [CNT_W-1:0] MULT_L  = CNT_W'(MULT_SETTLE_CYC);
  localparam logic [CNT_W-1:0] PWRUP_L = CNT_W'(PWRUP_SETTLE_CYC);

  logic [MULT_W-1:0] mult_q;
  logic [CNT_W-1:0]  cnt_q, load_val;
  logic              load, mult_chg;

  assign mult_chg = (mult_s_i != mult_q);

  // overlapping events keep the longest remaining interval
  always_comb begin
    load     = 1'b0;
    load_val = '0;
    if (state_i == ST_DOWN && state_next_i != ST_DOWN) begin
      load = 1'b1;
      if (PWRUP_L > load_val) load_val = PWRUP_L;
    end
    if (state_i == ST_HOLD && state_next_i == ST_RUN) begin
      load = 1'b1;
      if (STOP_L > load_val) load_val = STOP_L;
    end
    if (mult_chg && state_next_i != ST_DOWN) begin
      load = 1'b1;
      if (MULT_L > load_val) load_val = MULT_L;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q <= '0;
      cnt_q  <= '0;
    end else begin
      mult_q <= mult_s_i;
      if (state_next_i == ST_DOWN) cnt_q <= '0;
      else if (load)               cnt_q <= (load_val > cnt_q) ? load_val : cnt_q;
      else if (cnt_q != '0)        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign settled_o = (state_i == ST_RUN) && (cnt_q == '0);

  assert_mult_unsettle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mult_chg && state_next_i != ST_DOWN) |=> !settled_o);

  assert_powerup_unsettle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DOWN && state_next_i != ST_DOWN) |=> !settled_o);
endmodule

// File: rtl/cg_out_decode.sv
module cg_out_decode
  import clkgen_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic [2:0] mode_i,
  output src_e       src_o,
  output logic       hiz_o,
  output logic       park_gnd_o,
  output logic       park_stop_o
);
  always_comb begin
    src_o       = SRC_ALIGN;
    hiz_o       = 1'b0;
    park_gnd_o  = 1'b0;
    park_stop_o = 1'b0;
    unique case (state_i)
      ST_HOLD: park_stop_o = 1'b1;
      ST_RUN: begin
        unique case (mode_i)
          3'b000:  src_o = SRC_ALIGN;
          3'b100:  src_o = SRC_PLL;
          3'b110:  src_o = SRC_REF;
          default: hiz_o = 1'b1;   // board test and reserved codes
        endcase
      end
      default: park_gnd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_pkg::*;
#(
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned STOP_SETTLE_CYC  = 20,
  parameter int unsigned STOP_MAX_CYC     = 10000,
  parameter int unsigned RUN_MIN_CYC      = 10000,
  parameter int unsigned MULT_SETTLE_CYC  = 100000,
  parameter int unsigned PWRUP_SETTLE_CYC = 300000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       pd_ni,
  input  logic       stop_ni,
  input  logic [1:0] mult_i,
  output logic [1:0] state_o,
  output logic [1:0] src_sel_o,
  output logic       hiz_o,
  output logic       park_gnd_o,
  output logic       park_stop_o,
  output logic       settled_o,
  output logic       stop_long_o,
  output logic       stop_early_o
);
  localparam int unsigned SYNC_W = 7;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic [2:0]        mode_s, mode_q;
  logic [1:0]        mult_s;
  logic              pd_s, stop_s;
  pwr_state_e        state_q, state_d;
  src_e              src;

  assign raw_in = {mult_i, mode_i, stop_ni, pd_ni};
  assign {mult_s, mode_s, stop_s, pd_s} = sync_out;

  cg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(sync_out)
  );

  cg_power_fsm #(.STOP_MAX_CYC(STOP_MAX_CYC), .RUN_MIN_CYC(RUN_MIN_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .pd_n_s_i(pd_s), .stop_n_s_i(stop_s), .mode_s_i(mode_s),
    .state_o(state_q), .state_next_o(state_d), .mode_o(mode_q),
    .stop_long_o, .stop_early_o
  );

  cg_settle_timer #(
    .MULT_W(2), .STOP_SETTLE_CYC(STOP_SETTLE_CYC),
    .MULT_SETTLE_CYC(MULT_SETTLE_CYC), .PWRUP_SETTLE_CYC(PWRUP_SETTLE_CYC)
  ) u_timer (
    .clk_i, .rst_ni, .state_i(state_q), .state_next_i(state_d),
    .mult_s_i(mult_s), .settled_o
  );

  cg_out_decode u_dec (
    .state_i(state_q), .mode_i(mode_q), .src_o(src),
    .hiz_o, .park_gnd_o, .park_stop_o
  );

  assign state_o   = state_q;
  assign src_sel_o = src;

  assert_park_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({park_gnd_o, park_stop_o, hiz_o}));

  assert_src_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_o != 2'd3);
endmodule

// File: tb/sim_clkgen_mode_ctrl.sv
`timescale 1ns/1ps
module sim_clkgen_mode_ctrl;
  localparam int unsigned STOP_SET = 20;
  localparam int unsigned STOP_MAX = 40;
  localparam int unsigned RUN_MIN  = 16;
  localparam int unsigned MULT_SET = 30;
  localparam int unsigned PWRUP    = 60;
  localparam int unsigned LAT      = 3;

  // {mode, hiz, src}
  localparam logic [5:0] MODE_TAB [8] = '{
    {3'b000, 1'b0, 2'd0}, {3'b100, 1'b0, 2'd1}, {3'b110, 1'b0, 2'd2},
    {3'b010, 1'b1, 2'd0}, {3'b011, 1'b1, 2'd0}, {3'b001, 1'b1, 2'd0},
    {3'b101, 1'b1, 2'd0}, {3'b111, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic [2:0] mode_i;
  logic pd_ni, stop_ni;
  logic [1:0] mult_i;
  logic [1:0] state_o, src_sel_o;
  logic hiz_o, park_gnd_o, park_stop_o, settled_o, stop_long_o, stop_early_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  clkgen_mode_ctrl #(
    .STOP_SETTLE_CYC(STOP_SET), .STOP_MAX_CYC(STOP_MAX), .RUN_MIN_CYC(RUN_MIN),
    .MULT_SETTLE_CYC(MULT_SET), .PWRUP_SETTLE_CYC(PWRUP)
  ) u0 (
    .clk_i(clk), .rst_ni, .mode_i, .pd_ni, .stop_ni, .mult_i,
    .state_o, .src_sel_o, .hiz_o, .park_gnd_o, .park_stop_o,
    .settled_o, .stop_long_o, .stop_early_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // called at the falling edge just after the run state begins
  task automatic check_settle(input int n, input string tag);
    tick(n - 1);
    chk({tag, " settled still low"}, settled_o, 0);
    tick(1);
    chk({tag, " settled high"}, settled_o, 1);
  endtask

  // from stop: run for len cycles, then stop again
  task automatic run_then_stop(input int len, input int exp_early);
    stop_ni = 1'b1;
    tick(len);
    stop_ni = 1'b0;
    tick(LAT);
    chk("R12 state stop", state_o, 1);
    chk($sformatf("R12 early flag after run of %0d", len), stop_early_o, exp_early);
    tick(2);
    chk("R12 early flag held", stop_early_o, exp_early);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pd_ni = 1'b1; stop_ni = 1'b1; mode_i = 3'b100; mult_i = 2'b00;
    tick(3);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset park_gnd", park_gnd_o, 1);
    chk("R1 reset park_stop", park_stop_o, 0);
    chk("R1 reset hiz", hiz_o, 0);
    chk("R1 reset settled", settled_o, 0);
    chk("R1 reset flags", {stop_long_o, stop_early_o}, 0);

    pd_ni = 1'b0; mode_i = 3'b110;
    rst_ni = 1'b1;
    tick(5);
    chk("R3 down with stop high", state_o, 0);
    chk("R3 park_gnd", park_gnd_o, 1);
    chk("R3 hiz low", hiz_o, 0);

    // power-up, latency check
    pd_ni = 1'b1;
    tick(LAT - 1);
    chk("R2 not yet after two edges", state_o, 0);
    tick(1);
    chk("R2 run on third edge", state_o, 2);
    chk("R5 reference source", src_sel_o, 2);
    check_settle(PWRUP, "R9 power-up");

    for (int i = 0; i < 8; i++) begin
      mode_i = MODE_TAB[i][5:3];
      tick(LAT);
      chk($sformatf("R5 R6 R7 hiz mode %b", MODE_TAB[i][5:3]), hiz_o, MODE_TAB[i][2]);
      chk($sformatf("R5 R6 R7 src mode %b", MODE_TAB[i][5:3]), src_sel_o, MODE_TAB[i][1:0]);
      chk("R5 no park in run", {park_gnd_o, park_stop_o}, 0);
    end

    mode_i = 3'b000;
    tick(LAT);
    stop_ni = 1'b0;
    tick(LAT);
    chk("R4 stop state", state_o, 1);
    chk("R4 park_stop", park_stop_o, 1);
    chk("R4 park_gnd low", park_gnd_o, 0);
    chk("R9 settled low in stop", settled_o, 0);
    chk("R12 no early after power-up run", stop_early_o, 0);
    tick(STOP_MAX - 1);
    chk("R11 long flag before limit", stop_long_o, 0);
    tick(1);
    chk("R11 long flag at limit", stop_long_o, 1);

    stop_ni = 1'b1;
    tick(LAT);
    chk("R11 run after long stop", state_o, 2);
    chk("R11 long flag cleared", stop_long_o, 0);
    check_settle(STOP_SET, "R8 stop exit");

    stop_ni = 1'b0;
    tick(LAT);
    chk("R12 no early after long run", stop_early_o, 0);
    run_then_stop(10, 1);
    run_then_stop(RUN_MIN - 1, 1);
    run_then_stop(RUN_MIN, 0);

    stop_ni = 1'b1;
    tick(LAT + STOP_SET + 2);
    chk("R8 settled in run", settled_o, 1);
    chk("R12 early cleared in run", stop_early_o, 0);
    mult_i = 2'b01;
    tick(LAT - 1);
    chk("R10 settled before sync", settled_o, 1);
    tick(1);
    chk("R10 settled cleared", settled_o, 0);
    tick(MULT_SET - 1);
    chk("R10 still resettling", settled_o, 0);
    tick(1);
    chk("R10 resettled", settled_o, 1);

    mode_i = 3'b011;
    tick(LAT);
    chk("R6 hiz in run", hiz_o, 1);
    stop_ni = 1'b0;
    tick(LAT);
    chk("R4 stop overrides hiz mode", hiz_o, 0);
    chk("R4 park_stop with hiz mode", park_stop_o, 1);

    pd_ni = 1'b0;
    tick(LAT);
    chk("R3 down from stop", state_o, 0);
    chk("R3 park_gnd", park_gnd_o, 1);
    chk("R3 park_stop low", park_stop_o, 0);
    chk("R3 hiz low", hiz_o, 0);
    chk("R3 settled low", settled_o, 0);
    stop_ni = 1'b1;
    mult_i = 2'b10;
    tick(LAT + 2);
    chk("R3 stop release ignored", state_o, 0);
    chk("R3 flags low", {stop_long_o, stop_early_o}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule